// File: doc/BRIEF.md
# Channel Interrupt Queue Controller

This block gathers tone-disable events from a bank of echo-canceller channels and turns each one into a queued interrupt for a host processor. Each channel has two event sources, canceller A and canceller B. Each source reports as a level line. A rising edge on either line is one event for that channel. When an event passes the masks, the number of its channel joins a small first-in first-out queue. The host then reads queue entries one at a time and learns which channel needs service.

An active-low interrupt line is low while entries wait in the queue. It goes high after every queue read, so the host sees a separate low pulse for each entry. The block also keeps a tone-disable flag for each channel. That flag records every edge, masked or not. After learning a channel number, the host reads the flag, and the read clears it. One global mask bit blocks all queuing. Two per-channel mask bits block the A source and the B source on their own.

Writes to the mask registers and reads of the queue and of the status flags use simple one-cycle strobes. The block has no bus protocol.

Top module: `chan_irq_queue`

## Requirements
- R1: A one-cycle `fifo_rd` strobe returns the oldest queued channel on `rd_chan`, with `rd_valid`=1, on the cycle after the strobe and removes it; channels come out in the order they were queued.
- R2: An event is a rising edge of `td_a[i]` or `td_b[i]`; rising edges on both lines of a channel in the same cycle queue one entry, and a line held high queues nothing further.
- R3: When several channels raise unmasked events in the same cycle, they are queued lowest channel number first.
- R4: `irq_n` goes low two clock edges after the edge that captures an unmasked event into an empty queue, and stays low while entries remain and no read is in progress.
- R5: After each `fifo_rd` strobe `irq_n` is high for the two following cycles; it then goes low again if entries remain.
- R6: A `fifo_rd` strobe on an empty queue returns `rd_valid`=0 and leaves `irq_n` high.
- R7: A write with `cfg_main`=1 sets the global mask from `cfg_wdata[5]`; while it is 1, no event is queued.
- R8: A write with `cfg_main`=0 to channel `cfg_chan` sets that channel's A-source mask from `cfg_wdata[3]` and its B-source mask from `cfg_wdata[4]`; a masked source queues nothing.
- R9: Every edge sets the channel's tone-disable flag, whatever the masks. A `st_rd` strobe returns the flag of `st_chan` on `st_td` one cycle later and clears it, unless a new edge on that channel arrives in the same cycle.
- R10: The queue holds 16 entries. An event that finds the queue full is dropped, and `overflow` goes to 1 and stays at 1 until reset.
- R11: A synchronous reset empties the queue, drives `irq_n` high, clears `overflow` and all flags, and sets the global mask and every per-channel mask to 1 (masked).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| td_a | input | 32 | Tone-disable level from canceller A, one bit per channel |
| td_b | input | 32 | Tone-disable level from canceller B, one bit per channel |
| cfg_wr | input | 1 | Mask register write strobe |
| cfg_main | input | 1 | 1 selects the global control register, 0 selects a channel register |
| cfg_chan | input | 5 | Channel addressed by a channel register write |
| cfg_wdata | input | 16 | Write data (bit 5 global mask, bit 4 B mask, bit 3 A mask) |
| fifo_rd | input | 1 | Queue read strobe |
| rd_valid | output | 1 | 1 when the last queue read returned an entry |
| rd_chan | output | 5 | Channel number returned by the last queue read |
| st_rd | input | 1 | Status flag read strobe |
| st_chan | input | 5 | Channel whose flag is read |
| st_td | output | 1 | Tone-disable flag returned by the last status read |
| irq_n | output | 1 | Active-low interrupt |
| overflow | output | 1 | Sticky queue overflow flag |

## Verification
The bench raises edges on several channels in the same cycle. A design with a wrong priority encoder would return those channels in the wrong order, or would lose some of them. It also holds a line high for many cycles, to catch a design that queues on level instead of on edge, and it raises both sources of one channel at once, to catch a design that queues the channel twice. It fills the queue past its depth and then drains it. A design that overwrote the oldest entry, dropped the wrong event or let the overflow flag clear would return a wrong sequence. Random mask and source patterns check that masked edges still set the status flag but never reach the queue. Reads of an empty queue check that no stale entry comes back and that the interrupt line does not fall.

// File: rtl/ciq_pkg.sv
package ciq_pkg;
  localparam int GLOBAL_MASK_BIT = 5;
  localparam int SRC_B_MASK_BIT  = 4;
  localparam int SRC_A_MASK_BIT  = 3;
  localparam int CFG_W           = 16;

  // decides whether the edges of one channel may enter the queue
  function automatic logic evt_passes(input logic edge_a, input logic edge_b,
                                      input logic mask_a, input logic mask_b,
                                      input logic glob_mask);
    return !glob_mask && ((edge_a && !mask_a) || (edge_b && !mask_b));
  endfunction

  // next position of a circular pointer
  function automatic int unsigned ptr_step(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/ciq_event_capture.sv
module ciq_event_capture
  import ciq_pkg::*;
#(
  parameter int NUM_CH = 32,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] td_a,
  input  logic [NUM_CH-1:0] td_b,
  input  logic              cfg_wr,
  input  logic              cfg_main,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              st_rd,
  input  logic [CH_W-1:0]   st_chan,
  input  logic              q_full,
  output logic              q_push,
  output logic              q_drop,
  output logic [CH_W-1:0]   q_chan,
  output logic              st_td
);
  logic [NUM_CH-1:0] a_q, b_q, edge_a, edge_b, new_evt;
  logic [NUM_CH-1:0] mask_a, mask_b, td_flag, pend, grant, td_clr;
  logic              glob_mask, pend_any;

  function automatic logic [CH_W-1:0] lowest_set(input logic [NUM_CH-1:0] v);
    logic [CH_W-1:0] r;
    r = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (v[i]) r = CH_W'(i);
    return r;
  endfunction

  assign edge_a = td_a & ~a_q;
  assign edge_b = td_b & ~b_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    assign new_evt[g] = evt_passes(edge_a[g], edge_b[g], mask_a[g], mask_b[g], glob_mask);
    assign td_clr[g]  = st_rd && (st_chan == CH_W'(g));
  end

  assign pend_any = |pend;
  assign q_chan   = lowest_set(pend);
  assign grant    = pend_any ? (NUM_CH'(1) << q_chan) : '0;
  assign q_push   = pend_any && !q_full;
  assign q_drop   = pend_any && q_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q       <= '0;
      b_q       <= '0;
      pend      <= '0;
      td_flag   <= '0;
      mask_a    <= '1;
      mask_b    <= '1;
      glob_mask <= 1'b1;
      st_td     <= 1'b0;
    end else begin
      a_q     <= td_a;
      b_q     <= td_b;
      pend    <= (pend & ~grant) | new_evt;
      td_flag <= (td_flag & ~td_clr) | edge_a | edge_b;
      if (st_rd) st_td <= td_flag[st_chan];
      if (cfg_wr) begin
        if (cfg_main) begin
          glob_mask <= cfg_wdata[GLOBAL_MASK_BIT];
        end else begin
          mask_a[cfg_chan] <= cfg_wdata[SRC_A_MASK_BIT];
          mask_b[cfg_chan] <= cfg_wdata[SRC_B_MASK_BIT];
        end
      end
    end
  end

  // R9: a status read without a coinciding edge leaves the flag cleared
  assert_td_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (st_rd && !edge_a[st_chan] && !edge_b[st_chan]) |=> !td_flag[$past(st_chan)]);

  // R9: any edge, masked or not, leaves its flag set
  assert_td_set_R9: assert property (@(posedge clk) disable iff (rst)
    (|(edge_a | edge_b)) |=> (|td_flag));

  // R7: under the global mask nothing new becomes pending
  assert_glob_block_R7: assert property (@(posedge clk) disable iff (rst)
    (glob_mask && !pend_any) |=> !pend_any);

  // R3: the granted channel is pending and no lower channel is
  assert_low_first_R3: assert property (@(posedge clk) disable iff (rst)
    pend_any |-> (pend[q_chan] && ((pend & ((NUM_CH'(1) << q_chan) - NUM_CH'(1))) == '0)));
endmodule

// File: rtl/ciq_fifo.sv
module ciq_fifo
  import ciq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int W     = 5,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         drop,
  input  logic         pop,
  output logic         empty,
  output logic         full,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic         overflow
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          do_pop, do_push;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && !full;

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_push) wptr <= AW'(ptr_step(int'(wptr), DEPTH));
      if (do_pop)  rptr <= AW'(ptr_step(int'(rptr), DEPTH));
      count <= count + CW'(do_push) - CW'(do_pop);
      if (pop) begin
        rd_valid <= !empty;
        rd_data  <= empty ? '0 : mem[rptr];
      end
      if (drop) overflow <= 1'b1;
    end
  end

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  assert_no_push_full_R10: assert property (@(posedge clk) disable iff (rst)
    !(push && full));

  assert_overflow_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  assert_empty_read_R6: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> !rd_valid);

  assert_pop_valid_R1: assert property (@(posedge clk) disable iff (rst)
    (pop && !empty) |=> rd_valid);
endmodule

// File: rtl/ciq_irq_gen.sv
module ciq_irq_gen (
  input  logic clk,
  input  logic rst,
  input  logic rd_strobe,
  input  logic q_nonempty,
  output logic irq_n
);
  logic hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold  <= 1'b0;
      irq_n <= 1'b1;
    end else begin
      hold  <= rd_strobe;
      irq_n <= !(q_nonempty && !rd_strobe && !hold);
    end
  end

  // R5: high on the cycle after a read
  assert_release_R5: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |=> irq_n);

  // R5: still high on the second cycle after a read
  assert_gap_R5: assert property (@(posedge clk) disable iff (rst)
    hold |=> irq_n);

  // R4: the line is only low while entries remain
  assert_low_needs_entry_R4: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> q_nonempty);
endmodule

// File: rtl/chan_irq_queue.sv
module chan_irq_queue
  import ciq_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int DEPTH  = 16,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] td_a,
  input  logic [NUM_CH-1:0] td_b,
  input  logic              cfg_wr,
  input  logic              cfg_main,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              fifo_rd,
  output logic              rd_valid,
  output logic [CH_W-1:0]   rd_chan,
  input  logic              st_rd,
  input  logic [CH_W-1:0]   st_chan,
  output logic              st_td,
  output logic              irq_n,
  output logic              overflow
);
  logic            q_push, q_drop, q_empty, q_full;
  logic [CH_W-1:0] q_chan;

  ciq_event_capture #(.NUM_CH(NUM_CH)) u_capture (
    .clk(clk), .rst(rst), .td_a(td_a), .td_b(td_b),
    .cfg_wr(cfg_wr), .cfg_main(cfg_main), .cfg_chan(cfg_chan), .cfg_wdata(cfg_wdata),
    .st_rd(st_rd), .st_chan(st_chan), .q_full(q_full),
    .q_push(q_push), .q_drop(q_drop), .q_chan(q_chan), .st_td(st_td)
  );

  ciq_fifo #(.DEPTH(DEPTH), .W(CH_W)) u_fifo (
    .clk(clk), .rst(rst), .push(q_push), .din(q_chan), .drop(q_drop),
    .pop(fifo_rd), .empty(q_empty), .full(q_full),
    .rd_valid(rd_valid), .rd_data(rd_chan), .overflow(overflow)
  );

  ciq_irq_gen u_irq (
    .clk(clk), .rst(rst), .rd_strobe(fifo_rd), .q_nonempty(!q_empty), .irq_n(irq_n)
  );

  // R11: reset leaves the interrupt released and no overflow
  assert_reset_state_R11: assert property (@(posedge clk)
    rst |=> (irq_n && !overflow && !rd_valid));
endmodule

// File: tb/chan_irq_queue_test.sv
module chan_irq_queue_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] td_a, td_b;
  logic        cfg_wr, cfg_main;
  logic [4:0]  cfg_chan;
  logic [15:0] cfg_wdata;
  logic        fifo_rd;
  logic        rd_valid;
  logic [4:0]  rd_chan;
  logic        st_rd;
  logic [4:0]  st_chan;
  logic        st_td;
  logic        irq_n;
  logic        overflow;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  chan_irq_queue uut (
    .clk(clk), .rst(rst), .td_a(td_a), .td_b(td_b),
    .cfg_wr(cfg_wr), .cfg_main(cfg_main), .cfg_chan(cfg_chan), .cfg_wdata(cfg_wdata),
    .fifo_rd(fifo_rd), .rd_valid(rd_valid), .rd_chan(rd_chan),
    .st_rd(st_rd), .st_chan(st_chan), .st_td(st_td),
    .irq_n(irq_n), .overflow(overflow)
  );

  function automatic bit expect_queued(bit glob, bit ma, bit mb, bit a, bit b);
    if (glob) return 0;
    return (a & ~ma) | (b & ~mb);
  endfunction

  function automatic logic [15:0] chan_word(bit ma, bit mb);
    logic [15:0] w;
    w = 16'h0;
    w[3] = ma;
    w[4] = mb;
    return w;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_main(bit glob);
    @(negedge clk);
    cfg_wr = 1; cfg_main = 1; cfg_wdata = 16'h0; cfg_wdata[5] = glob;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic write_chan(int ch, bit ma, bit mb);
    @(negedge clk);
    cfg_wr = 1; cfg_main = 0; cfg_chan = 5'(ch); cfg_wdata = chan_word(ma, mb);
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic pulse(int ch, bit a, bit b);
    @(negedge clk);
    td_a[ch] = a; td_b[ch] = b;
    @(negedge clk);
    td_a[ch] = 0; td_b[ch] = 0;
  endtask

  task automatic q_read(output bit v, output int ch);
    @(negedge clk);
    fifo_rd = 1;
    @(negedge clk);
    fifo_rd = 0;
    v = rd_valid; ch = int'(rd_chan);
  endtask

  task automatic st_read(int ch, output bit td);
    @(negedge clk);
    st_rd = 1; st_chan = 5'(ch);
    @(negedge clk);
    st_rd = 0;
    td = st_td;
  endtask

  // read one entry and check the line stays high around the read (R5)
  task automatic q_read_irq(output bit v, output int ch, input bit more_left);
    q_read(v, ch);
    check(irq_n === 1'b1, "R5 high after read", irq_n, 1);
    @(negedge clk);
    check(irq_n === 1'b1, "R5 high second cycle", irq_n, 1);
    @(negedge clk);
    check(irq_n === !more_left, "R5 low again if left", irq_n, !more_left);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    bit v, td;
    int ch;
    void'($urandom(32'h5eed1234));
    rst = 1; td_a = '0; td_b = '0; cfg_wr = 0; cfg_main = 0; cfg_chan = '0;
    cfg_wdata = '0; fifo_rd = 0; st_rd = 0; st_chan = '0;
    idle(3);
    rst = 0;
    idle(1);

    // R11: state right after reset
    check(irq_n === 1'b1, "R11 irq_n", irq_n, 1);
    check(overflow === 1'b0, "R11 overflow", overflow, 0);
    st_read(7, td);
    check(td === 1'b0, "R11 flag clear", td, 0);
    // R11: everything masked, so an edge is flagged but not queued
    pulse(7, 1, 1);
    idle(3);
    check(irq_n === 1'b1, "R11 masked after reset", irq_n, 1);
    q_read(v, ch);
    check(v === 1'b0, "R11 queue empty", v, 0);
    check(irq_n === 1'b1, "R6 empty read leaves irq high", irq_n, 1);
    st_read(7, td);
    check(td === 1'b1, "R9 masked edge still flagged", td, 1);
    st_read(7, td);
    check(td === 1'b0, "R9 flag cleared by read", td, 0);

    write_main(0);
    for (int i = 0; i < 32; i++) write_chan(i, 0, 0);

    // R4: timing of the low level
    @(negedge clk); td_a[2] = 1;
    @(negedge clk); td_a[2] = 0;
    check(irq_n === 1'b1, "R4 not yet low", irq_n, 1);
    @(negedge clk);
    check(irq_n === 1'b1, "R4 one edge later", irq_n, 1);
    @(negedge clk);
    check(irq_n === 1'b0, "R4 low after two edges", irq_n, 0);
    q_read_irq(v, ch, 0);
    check(v && ch == 2, "R1 entry channel", ch, 2);

    // R2: level held high queues once; both sources at once queue once
    @(negedge clk); td_a[11] = 1;
    idle(8);
    td_a[11] = 0;
    pulse(12, 1, 1);
    idle(2);
    q_read_irq(v, ch, 1);
    check(v && ch == 11, "R2 held level one entry", ch, 11);
    q_read_irq(v, ch, 0);
    check(v && ch == 12, "R2 both sources one entry", ch, 12);
    q_read(v, ch);
    check(v === 1'b0, "R2 no duplicate", v, 0);

    // R3: same-cycle events leave lowest channel first
    @(negedge clk); td_a[20] = 1; td_b[9] = 1; td_a[3] = 1; td_b[30] = 1;
    @(negedge clk); td_a = '0; td_b = '0;
    idle(5);
    q_read_irq(v, ch, 1); check(v && ch == 3,  "R3 first",  ch, 3);
    q_read_irq(v, ch, 1); check(v && ch == 9,  "R3 second", ch, 9);
    q_read_irq(v, ch, 1); check(v && ch == 20, "R3 third",  ch, 20);
    q_read_irq(v, ch, 0); check(v && ch == 30, "R3 fourth", ch, 30);
    q_read(v, ch);
    check(v === 1'b0, "R6 drained read", v, 0);

    // R8: per-source masks; R7: global mask
    write_chan(5, 1, 0);
    pulse(5, 1, 0); idle(3);
    q_read(v, ch); check(v === 1'b0, "R8 A masked", v, 0);
    pulse(5, 0, 1); idle(3);
    q_read(v, ch); check(v && ch == 5, "R8 B unmasked", ch, 5);
    write_chan(5, 0, 1);
    pulse(5, 0, 1); idle(3);
    q_read(v, ch); check(v === 1'b0, "R8 B masked", v, 0);
    write_chan(5, 0, 0);
    write_main(1);
    pulse(5, 1, 1); idle(3);
    check(irq_n === 1'b1, "R7 global mask irq", irq_n, 1);
    q_read(v, ch); check(v === 1'b0, "R7 global mask queue", v, 0);
    write_main(0);

    // random masks and sources against the bench prediction
    for (int it = 0; it < 60; it++) begin
      int  c;
      bit  ma, mb, gl, a, b, e;
      c  = int'($urandom_range(31, 0));
      ma = 1'($urandom); mb = 1'($urandom); gl = ($urandom_range(7, 0) == 0);
      a  = 1'($urandom); b = 1'($urandom);
      if (!a && !b) a = 1;
      write_chan(c, ma, mb);
      write_main(gl);
      pulse(c, a, b);
      idle(2);
      e = expect_queued(gl, ma, mb, a, b);
      check(irq_n === !e, "R4 random irq", irq_n, !e);
      q_read(v, ch);
      check(v === e, "R8 random queued", v, e);
      if (e) check(ch == c, "R1 random channel", ch, c);
      st_read(c, td);
      check(td === 1'b1, "R9 random flag", td, 1);
    end
    write_main(0);
    for (int i = 0; i < 17; i++) write_chan(i, 0, 0);
    for (int i = 0; i < 32; i++) st_read(i, td);

    // R10: 17 events into a 16-entry queue
    for (int i = 0; i < 17; i++) pulse(i, 1, 0);
    idle(2);
    check(overflow === 1'b1, "R10 overflow set", overflow, 1);
    for (int i = 0; i < 16; i++) begin
      q_read_irq(v, ch, i < 15);
      check(v && ch == i, "R10 kept order", ch, i);
    end
    q_read(v, ch);
    check(v === 1'b0, "R10 last event dropped", v, 0);
    check(overflow === 1'b1, "R10 overflow sticky", overflow, 1);

    // R11: reset clears overflow
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check(overflow === 1'b0, "R11 overflow cleared", overflow, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule